// File: doc/BRIEF.md
# Filter Input Voice Router

This block sits in front of a resonant audio filter. On each sample strobe it takes three signed voice samples and one external audio sample. Each is cut to a narrower width by an arithmetic right shift. The scaled samples are then split into two sums: one drives the filter and one goes around it. A four-bit routing mask picks which sources feed the filter.

A voice-3 mute and a global filter enable also act on the split. The mute silences voice 3 only when voice 3 goes around the filter. When voice 3 is routed into the filter, the mute has no effect. Clearing the enable sends every source to the bypass sum. It also raises a clear request so that the downstream integrators reset their state.

Both sums and the clear request are registered. They change only on a clock edge at which the sample strobe is high. The filter arithmetic and the output volume stage live elsewhere.

Top module: `flt_route_mix`

## Requirements
- R1: Each 20-bit two's-complement input is reduced to a 13-bit value equal to an arithmetic right shift by 7, rounding toward minus infinity. For example, -1 gives -1, 127 gives 0, 128 gives 1 and -129 gives -2.
- R2: With the filter enabled, each mask bit routes one source into the filter sum when set and into the bypass sum when clear. The bit assignment is: bit 0 is voice 1, bit 1 is voice 2, bit 2 is voice 3, and bit 3 is the external input.
- R3: Both sums are 15-bit two's complement and hold any combination of four scaled operands without overflow. Four full-scale negatives give -16384, and four full-scale positives give 16380.
- R4: With the filter enabled, a mask of 0 gives a filter sum of zero, and a mask of 0xF gives a bypass sum of zero.
- R5: When the mute is high, voice 3 counts as zero if mask bit 2 is clear. When mask bit 2 is set, the mute is ignored. This mask test applies whether or not the filter is enabled.
- R6: With the filter disabled, the filter sum is zero, the bypass sum holds all four scaled sources (subject to R5), and the clear request is high.
- R7: A strobe with the filter enabled drives the clear request low.
- R8: The outputs take new values one clock edge after a strobe is sampled high. On edges where the strobe is low, the outputs hold their values whatever the inputs do.
- R9: An active-low reset, asserted asynchronously, sets both sums to zero and the clear request high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_vld_i | input | 1 | Sample strobe; captures a new result |
| voice1_i | input | 20 | Voice 1 sample, two's complement |
| voice2_i | input | 20 | Voice 2 sample, two's complement |
| voice3_i | input | 20 | Voice 3 sample, two's complement |
| extin_i | input | 20 | External audio sample, two's complement |
| route_mask_i | input | 4 | Filter routing mask |
| v3_mute_i | input | 1 | Voice-3 mute |
| flt_en_i | input | 1 | Filter enable |
| flt_sum_o | output | 15 | Registered filter input sum |
| byp_sum_o | output | 15 | Registered bypass sum |
| flt_clr_o | output | 1 | Registered filter state clear request |

## Verification
The sweep covers every mask with each mute and enable setting, over sample sets that include full-scale values and values just either side of a shift boundary.

Each likely fault shows up in a specific way:
- A logical instead of arithmetic shift turns small negatives into large positives.
- A mute applied regardless of the mask drops voice 3 from the filter sum.
- A mute test that looks at the enable makes the bypass sum wrong when the filter is disabled.
- Sums that are too narrow wrap on four full-scale negatives.
- Swapped mask bits move the wrong source between the sums.
- A missing strobe gate lets the outputs follow input changes made between strobes.

// File: rtl/flt_route_pkg.sv
package flt_route_pkg;
  localparam int unsigned N_SRC  = 4;
  localparam int unsigned SRC_V3 = 2;
endpackage

// File: rtl/fr_scale.sv
module fr_scale #(
  parameter int unsigned N     = 4,
  parameter int unsigned IN_W  = 20,
  parameter int unsigned SHIFT = 7,
  localparam int unsigned SC_W = IN_W - SHIFT
) (
  input  logic [N-1:0][IN_W-1:0] raw_i,
  output logic [N-1:0][SC_W-1:0] scaled_o
);
  // Keeping the upper bits of a two's-complement word is an arithmetic
  // shift truncated to the result width.
  for (genvar g = 0; g < N; g++) begin : g_src
    assign scaled_o[g] = raw_i[g][IN_W-1:SHIFT];
  end
endmodule

// File: rtl/fr_split.sv
module fr_split #(
  parameter int unsigned N     = 4,
  parameter int unsigned SC_W  = 13,
  parameter int unsigned SUM_W = 15,
  parameter int unsigned MUTE_IDX = 2
) (
  input  logic [N-1:0][SC_W-1:0] scaled_i,
  input  logic [N-1:0]           mask_i,
  input  logic                   mute_i,
  input  logic                   en_i,
  output logic [SUM_W-1:0]       flt_o,
  output logic [SUM_W-1:0]       byp_o
);
  localparam int unsigned EXT_W = SUM_W - SC_W;

  logic [N-1:0][SUM_W-1:0] wide;
  logic [N-1:0]            to_flt;

  for (genvar g = 0; g < N; g++) begin : g_ext
    if (g == MUTE_IDX) begin : g_muted
      logic kill;
      assign kill    = mute_i & ~mask_i[g];
      assign wide[g] = kill ? '0 : {{EXT_W{scaled_i[g][SC_W-1]}}, scaled_i[g]};
    end else begin : g_plain
      assign wide[g] = {{EXT_W{scaled_i[g][SC_W-1]}}, scaled_i[g]};
    end
    assign to_flt[g] = en_i & mask_i[g];
  end

  always_comb begin
    flt_o = '0;
    byp_o = '0;
    for (int k = 0; k < N; k++) begin
      if (to_flt[k]) flt_o = flt_o + wide[k];
      else           byp_o = byp_o + wide[k];
    end
  end
endmodule

// File: rtl/flt_route_mix.sv
module flt_route_mix
  import flt_route_pkg::*;
#(
  parameter int unsigned IN_W  = 20,
  parameter int unsigned SHIFT = 7,
  localparam int unsigned SC_W  = IN_W - SHIFT,
  localparam int unsigned SUM_W = SC_W + $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [IN_W-1:0]  voice1_i,
  input  logic [IN_W-1:0]  voice2_i,
  input  logic [IN_W-1:0]  voice3_i,
  input  logic [IN_W-1:0]  extin_i,
  input  logic [N_SRC-1:0] route_mask_i,
  input  logic             v3_mute_i,
  input  logic             flt_en_i,
  output logic [SUM_W-1:0] flt_sum_o,
  output logic [SUM_W-1:0] byp_sum_o,
  output logic             flt_clr_o
);
  logic [N_SRC-1:0][IN_W-1:0] raw;
  logic [N_SRC-1:0][SC_W-1:0] scaled;
  logic [SUM_W-1:0] flt_comb, byp_comb;
  logic [SUM_W-1:0] flt_q, flt_d, byp_q, byp_d;
  logic             clr_q, clr_d;

  assign raw = {extin_i, voice3_i, voice2_i, voice1_i};

  fr_scale #(.N(N_SRC), .IN_W(IN_W), .SHIFT(SHIFT)) u_scale (
    .raw_i    (raw),
    .scaled_o (scaled)
  );

  fr_split #(.N(N_SRC), .SC_W(SC_W), .SUM_W(SUM_W), .MUTE_IDX(SRC_V3)) u_split (
    .scaled_i (scaled),
    .mask_i   (route_mask_i),
    .mute_i   (v3_mute_i),
    .en_i     (flt_en_i),
    .flt_o    (flt_comb),
    .byp_o    (byp_comb)
  );

  always_comb begin
    flt_d = flt_q;
    byp_d = byp_q;
    clr_d = clr_q;
    if (smp_vld_i) begin
      flt_d = flt_comb;
      byp_d = byp_comb;
      clr_d = ~flt_en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= '0;
      byp_q <= '0;
      clr_q <= 1'b1;
    end else begin
      flt_q <= flt_d;
      byp_q <= byp_d;
      clr_q <= clr_d;
    end
  end

  assign flt_sum_o = flt_q;
  assign byp_sum_o = byp_q;
  assign flt_clr_o = clr_q;
endmodule

// File: rtl/flt_route_chk.sv
module flt_route_chk #(
  parameter int unsigned SUM_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_vld_i,
  input logic [3:0]       route_mask_i,
  input logic             flt_en_i,
  input logic [SUM_W-1:0] flt_sum_o,
  input logic [SUM_W-1:0] byp_sum_o,
  input logic             flt_clr_o
);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> ($stable(flt_sum_o) && $stable(byp_sum_o) && $stable(flt_clr_o)));

  a_r6_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && !flt_en_i) |=> (flt_sum_o == '0 && flt_clr_o));

  a_r7_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && flt_en_i) |=> !flt_clr_o);

  a_r4_mask_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && route_mask_i == 4'h0) |=> flt_sum_o == '0);

  a_r4_mask_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && flt_en_i && route_mask_i == 4'hF) |=> byp_sum_o == '0);
endmodule

bind flt_route_mix flt_route_chk #(.SUM_W(SUM_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_vld_i    (smp_vld_i),
  .route_mask_i (route_mask_i),
  .flt_en_i     (flt_en_i),
  .flt_sum_o    (flt_sum_o),
  .byp_sum_o    (byp_sum_o),
  .flt_clr_o    (flt_clr_o)
);

// File: tb/sim_flt_route_mix.sv
`timescale 1ns/1ps
module sim_flt_route_mix;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        smp_vld_i;
  logic [19:0] voice1_i, voice2_i, voice3_i, extin_i;
  logic [3:0]  route_mask_i;
  logic        v3_mute_i, flt_en_i;
  logic [14:0] flt_sum_o, byp_sum_o;
  logic        flt_clr_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  flt_route_mix u0 (
    .clk_i(clk), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i),
    .voice1_i(voice1_i), .voice2_i(voice2_i), .voice3_i(voice3_i), .extin_i(extin_i),
    .route_mask_i(route_mask_i), .v3_mute_i(v3_mute_i), .flt_en_i(flt_en_i),
    .flt_sum_o(flt_sum_o), .byp_sum_o(byp_sum_o), .flt_clr_o(flt_clr_o)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sc(logic [19:0] x);
    int v;
    v = int'($signed(x));
    if (v >= 0) return v / 128;
    return -((-v + 127) / 128);
  endfunction

  function automatic logic [19:0] pv(int p, int k);
    logic [19:0] t [4];
    case (p)
      0: t = '{20'h7FFFF, 20'h7FFFF, 20'h7FFFF, 20'h7FFFF};
      1: t = '{20'h80000, 20'h80000, 20'h80000, 20'h80000};
      2: t = '{20'h7FFFF, 20'h80000, 20'hFFFFF, 20'h00080};
      3: t = '{20'h0007F, 20'hFFF7F, 20'h00080, 20'h12345};
      4: t = '{20'hFFF80, 20'h3C000, 20'hC4000, 20'h00100};
      default: t = '{20'h01280, 20'hFE000, 20'h0BEEF, 20'hAB0CD};
    endcase
    return t[k];
  endfunction

  int lf, lb, lc;

  task automatic run(int p, int mask, bit mute, bit en);
    int s [4];
    int ef, eb;
    string tg;
    @(negedge clk);
    voice1_i = pv(p, 0); voice2_i = pv(p, 1); voice3_i = pv(p, 2); extin_i = pv(p, 3);
    route_mask_i = mask[3:0]; v3_mute_i = mute; flt_en_i = en; smp_vld_i = 1'b1;
    @(negedge clk);
    smp_vld_i = 1'b0;
    for (int k = 0; k < 4; k++) s[k] = sc(pv(p, k));
    if (mute && !mask[2]) s[2] = 0;
    ef = 0; eb = 0;
    for (int k = 0; k < 4; k++) begin
      if (en && mask[k]) ef += s[k];
      else eb += s[k];
    end
    if (!en)                                  tg = "R6";
    else if (mask == 0 || mask == 15)         tg = "R4";
    else if (mute)                            tg = "R5";
    else if (p < 2)                           tg = "R3";
    else if (p < 4)                           tg = "R1";
    else                                      tg = "R2";
    chk({tg, " filter sum"}, int'($signed(flt_sum_o)), ef);
    chk({tg, " bypass sum"}, int'($signed(byp_sum_o)), eb);
    chk(en ? "R7 clear low" : "R6 clear high", int'(flt_clr_o), en ? 0 : 1);
    lf = ef; lb = eb; lc = en ? 0 : 1;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; smp_vld_i = 1'b0;
    voice1_i = '0; voice2_i = '0; voice3_i = '0; extin_i = '0;
    route_mask_i = '0; v3_mute_i = 1'b0; flt_en_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset filter sum", int'($signed(flt_sum_o)), 0);
    chk("R9 reset bypass sum", int'($signed(byp_sum_o)), 0);
    chk("R9 reset clear", int'(flt_clr_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 6; p++)
      for (int m = 0; m < 16; m++)
        for (int mu = 0; mu < 2; mu++)
          for (int e = 0; e < 2; e++)
            run(p, m, mu[0], e[0]);

    // R8: inputs move with the strobe low; outputs must hold
    run(3, 5, 1'b0, 1'b1);
    @(negedge clk);
    voice1_i = 20'h7FFFF; voice2_i = 20'h80000; extin_i = 20'h55555;
    route_mask_i = 4'hA; flt_en_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 hold filter sum", int'($signed(flt_sum_o)), lf);
    chk("R8 hold bypass sum", int'($signed(byp_sum_o)), lb);
    chk("R8 hold clear", int'(flt_clr_o), lc);

    // R9: asynchronous reset in mid-run
    run(0, 3, 1'b0, 1'b1);
    #1.0;
    rst_ni = 1'b0;
    #0.5;
    chk("R9 async filter sum", int'($signed(flt_sum_o)), 0);
    chk("R9 async bypass sum", int'($signed(byp_sum_o)), 0);
    chk("R9 async clear", int'(flt_clr_o), 1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule